// File: doc/BRIEF.md
# Microprogram Next-Address Unit

This block computes the next current-instruction address of a microsequencer that drives a 16-bit control store. Each cycle it picks one of four sources: the present address, held for another cycle; the saved program counter of the task that is being switched in; the target address produced by the jump decoder; or, for a return, either the link/B-bus value or a page-preserving increment of the present address. On the non-hold, non-switch paths it then ORs a branch-condition result into bit 0.

The unit also supplies the page-preserving increment itself, and from the chosen address it derives the control-store row address and an active-low bank select. All outputs are registered, so each one appears one clock after the inputs that produce it. Target decoding and condition-flag generation are done by other blocks. This block only receives their results: the decoded target address and eight condition flags.

Top module: `uaddr_next`

## Requirements
- R1: When `repeatCur` is 1, `nextAddr` equals `curAddr` one cycle later. It overrides a task switch and every other source, and no branch result is ORed in.
- R2: When `taskSwitch` is 1 and `repeatCur` is 0, `nextAddr` is `{curAddr[15:14], savedPc[13:0]}` and no branch result is ORed in.
- R3: When none of `repeatCur`, `taskSwitch` or `isReturn` is 1, `nextAddr` is `{curAddr[15:14], targetAddr[13:0]}` ORed with the branch bit in bit 0.
- R4: `incAddr` is `{curAddr[15:6], (curAddr[5:0]+1) mod 64}`. It never carries into bit 6.
- R5: When `isReturn` is 1 and neither `repeatCur` nor `taskSwitch` is 1, `nextAddr` is `linkBus` if `linkWrite` is 1 and the R4 increment otherwise, ORed with the branch bit.
- R6: A condition selector value s picks `condFlags[s]`. The flag meanings are: 0 result zero, 1 result negative, 2 ALU carry, 3 counter zero, 4 R negative, 5 R odd, 6 I/O attention, 7 overflow.
- R7: The jump-code condition, selected by `jumpCode[2:0]`, counts only when `jumpCode` is above 8'o17 and below 8'o200 and `jumpCode[2:0]` is not 7.
- R8: When `funcCode[7:3]` equals 6, `condFlags[funcCode[2:0]]` is also ORed into the branch bit.
- R9: The branch bit is merged with OR, never added. An address whose bit 0 is already 1 is unchanged by a true branch, and no carry reaches bit 1.
- R10: `rowAddr` equals `nextAddr` shifted right by one.
- R11: `bankSelN` is active-low one-hot over `{nextAddr[11], nextAddr[0]}`: 00 gives 0111, 01 gives 1011, 10 gives 1101 and 11 gives 1110.
- R12: While `rstN` is low, `nextAddr`, `incAddr` and `rowAddr` are 0 and `bankSelN` is 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curAddr | input | 16 | Present instruction address |
| savedPc | input | 16 | Saved PC of the incoming task |
| targetAddr | input | 16 | Decoded jump target |
| linkBus | input | 16 | Link/B-bus value for returns |
| repeatCur | input | 1 | Repeat the present instruction |
| taskSwitch | input | 1 | A task switch takes effect |
| isReturn | input | 1 | Current jump is a return |
| linkWrite | input | 1 | Link write is active this cycle |
| jumpCode | input | 8 | Jump code; bits 2:0 select a condition |
| funcCode | input | 8 | Function code; can add a second condition |
| condFlags | input | 8 | Condition flags, indexed as in R6 |
| nextAddr | output | 16 | New current-instruction address |
| incAddr | output | 16 | Page-preserving increment of curAddr |
| rowAddr | output | 15 | Control-store row address |
| bankSelN | output | 4 | Active-low one-hot bank select |

## Verification
Two things can change bit 0 in the same cycle: the branch OR and the source address itself. A return with increment or a target whose bit 0 is already 1 can meet a true condition from the jump code, from the function code, or from both. The bench forces these overlaps deliberately and also sweeps random inputs. A reference model then judges each cycle: it expects bit 0 set, bits 15:1 untouched and the bank select following the merged bit. Holds and switches that arrive alongside true conditions show that those paths keep the branch out.

// File: rtl/uaddr_pkg.sv
package uaddr_pkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic selHold;
    logic selSaved;
    logic selLink;
    logic selInc;
    logic selTarget;
    logic branchBit;
  } uaddrStrobe_t;
endpackage

// File: rtl/uaddr_ctrl.sv
module uaddr_ctrl
  import uaddr_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int NFLAG   = 8,
  parameter int SEL_W   = $clog2(NFLAG),
  parameter int FUNC_BR = 6
) (
  input  logic              repeatCur,
  input  logic              taskSwitch,
  input  logic              isReturn,
  input  logic              linkWrite,
  input  logic [CODE_W-1:0] jumpCode,
  input  logic [CODE_W-1:0] funcCode,
  input  logic [NFLAG-1:0]  condFlags,
  output uaddrStrobe_t      strobe
);
  localparam logic [CODE_W-1:0] JUMP_LO = CODE_W'(8'o17);
  localparam logic [CODE_W-1:0] JUMP_HI = CODE_W'(8'o200);
  localparam logic [SEL_W-1:0]  SEL_NONE = {SEL_W{1'b1}};
  localparam int HI_W = CODE_W - SEL_W;

  logic [SEL_W-1:0] jumpSel;
  logic [SEL_W-1:0] funcSel;
  logic             jumpGate;
  logic             funcGate;
  logic             jumpCond;
  logic             funcCond;
  logic             pathTakesBranch;

  assign jumpSel = jumpCode[SEL_W-1:0];
  assign funcSel = funcCode[SEL_W-1:0];

  // Jump-code condition window
  assign jumpGate = (jumpCode > JUMP_LO) && (jumpCode < JUMP_HI) && (jumpSel != SEL_NONE);
  // Function-code second condition
  assign funcGate = (funcCode[CODE_W-1:SEL_W] == HI_W'(FUNC_BR));

  assign jumpCond = jumpGate & condFlags[jumpSel];
  assign funcCond = funcGate & condFlags[funcSel];

  assign pathTakesBranch = !repeatCur && !taskSwitch;

  always_comb begin
    strobe = '0;
    if (repeatCur) begin
      strobe.selHold = 1'b1;
    end else if (taskSwitch) begin
      strobe.selSaved = 1'b1;
    end else if (isReturn) begin
      if (linkWrite) strobe.selLink = 1'b1;
      else           strobe.selInc  = 1'b1;
    end else begin
      strobe.selTarget = 1'b1;
    end
    strobe.branchBit = pathTakesBranch & (jumpCond | funcCond);
  end
endmodule

// File: rtl/uaddr_dp.sv
module uaddr_dp
  import uaddr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int HI_W     = 2,
  parameter int PAGE_W   = 6,
  parameter int BANK_BIT = 11,
  parameter int NBANK    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  uaddrStrobe_t      strobe,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] savedPc,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [ADDR_W-1:0] linkBus,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [ADDR_W-1:0] incAddr,
  output logic [ADDR_W-2:0] rowAddr,
  output logic [NBANK-1:0]  bankSelN
);
  localparam int LO_W = ADDR_W - HI_W;
  localparam int BK_W = $clog2(NBANK);

  logic [ADDR_W-1:0] incComb;
  logic [ADDR_W-1:0] pickAddr;
  logic [ADDR_W-1:0] finalAddr;
  logic [BK_W-1:0]   bankCode;
  logic [NBANK-1:0]  bankComb;

  // Page-preserving increment
  assign incComb = {curAddr[ADDR_W-1:PAGE_W], curAddr[PAGE_W-1:0] + PAGE_W'(1)};

  always_comb begin
    pickAddr = {curAddr[ADDR_W-1:LO_W], targetAddr[LO_W-1:0]};
    if (strobe.selHold)  pickAddr = curAddr;
    if (strobe.selSaved) pickAddr = {curAddr[ADDR_W-1:LO_W], savedPc[LO_W-1:0]};
    if (strobe.selLink)  pickAddr = linkBus;
    if (strobe.selInc)   pickAddr = incComb;
  end

  // Branch result merged by OR into bit 0
  assign finalAddr = pickAddr | {{(ADDR_W-1){1'b0}}, strobe.branchBit};

  assign bankCode = {finalAddr[BANK_BIT], finalAddr[0]};

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    assign bankComb[k] = (bankCode != BK_W'(NBANK-1-k));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextAddr <= '0;
      incAddr  <= '0;
      rowAddr  <= '0;
      bankSelN <= {1'b0, {(NBANK-1){1'b1}}};
    end else begin
      nextAddr <= finalAddr;
      incAddr  <= incComb;
      rowAddr  <= finalAddr[ADDR_W-1:1];
      bankSelN <= bankComb;
    end
  end
endmodule

// File: rtl/uaddr_next.sv
module uaddr_next
  import uaddr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 8,
  parameter int NFLAG  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] savedPc,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [ADDR_W-1:0] linkBus,
  input  logic              repeatCur,
  input  logic              taskSwitch,
  input  logic              isReturn,
  input  logic              linkWrite,
  input  logic [CODE_W-1:0] jumpCode,
  input  logic [CODE_W-1:0] funcCode,
  input  logic [NFLAG-1:0]  condFlags,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [ADDR_W-1:0] incAddr,
  output logic [ADDR_W-2:0] rowAddr,
  output logic [3:0]        bankSelN
);
  uaddrStrobe_t strobe;

  uaddr_ctrl #(.CODE_W(CODE_W), .NFLAG(NFLAG)) ctrl_i (
    .repeatCur (repeatCur),
    .taskSwitch(taskSwitch),
    .isReturn  (isReturn),
    .linkWrite (linkWrite),
    .jumpCode  (jumpCode),
    .funcCode  (funcCode),
    .condFlags (condFlags),
    .strobe    (strobe)
  );

  uaddr_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .curAddr   (curAddr),
    .savedPc   (savedPc),
    .targetAddr(targetAddr),
    .linkBus   (linkBus),
    .nextAddr  (nextAddr),
    .incAddr   (incAddr),
    .rowAddr   (rowAddr),
    .bankSelN  (bankSelN)
  );
endmodule

// File: rtl/uaddr_next_chk.sv
module uaddr_next_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] curAddr,
  input logic [15:0] savedPc,
  input logic [15:0] targetAddr,
  input logic        repeatCur,
  input logic        taskSwitch,
  input logic        isReturn,
  input logic [15:0] nextAddr,
  input logic [15:0] incAddr,
  input logic [14:0] rowAddr,
  input logic [3:0]  bankSelN
);
  logic seenEdge;
  always_ff @(posedge clk) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  assert_hold_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && $past(repeatCur)) |-> (nextAddr == $past(curAddr)));

  assert_switch_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && !$past(repeatCur) && $past(taskSwitch)) |->
      (nextAddr == {$past(curAddr[15:14]), $past(savedPc[13:0])}));

  // R3 and R9: upper bits follow the target untouched by the branch OR
  assert_target_upper_R9: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && !$past(repeatCur) && !$past(taskSwitch) && !$past(isReturn)) |->
      ((nextAddr[15:1] == {$past(curAddr[15:14]), $past(targetAddr[13:1])}) &&
       (nextAddr[0] >= $past(targetAddr[0]))));

  assert_page_inc_R4: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge |-> ((incAddr[15:6] == $past(curAddr[15:6])) &&
                  (incAddr[5:0] == 6'($past(curAddr[5:0]) + 6'd1))));

  assert_row_shift_R10: assert property (@(posedge clk) disable iff (!rstN)
    rowAddr == nextAddr[15:1]);

  assert_bank_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(~bankSelN) == 1) && !bankSelN[3 - 2'({nextAddr[11], nextAddr[0]})]);
endmodule

bind uaddr_next uaddr_next_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .curAddr   (curAddr),
  .savedPc   (savedPc),
  .targetAddr(targetAddr),
  .repeatCur (repeatCur),
  .taskSwitch(taskSwitch),
  .isReturn  (isReturn),
  .nextAddr  (nextAddr),
  .incAddr   (incAddr),
  .rowAddr   (rowAddr),
  .bankSelN  (bankSelN)
);

// File: tb/uaddr_next_tb.sv
`timescale 1ns/1ps
module uaddr_next_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] curAddr = '0, savedPc = '0, targetAddr = '0, linkBus = '0;
  logic        repeatCur = 0, taskSwitch = 0, isReturn = 0, linkWrite = 0;
  logic [7:0]  jumpCode = '0, funcCode = '0, condFlags = '0;
  logic [15:0] nextAddr, incAddr;
  logic [14:0] rowAddr;
  logic [3:0]  bankSelN;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uaddr_next dut_i (
    .clk(clk), .rstN(rstN), .curAddr(curAddr), .savedPc(savedPc),
    .targetAddr(targetAddr), .linkBus(linkBus), .repeatCur(repeatCur),
    .taskSwitch(taskSwitch), .isReturn(isReturn), .linkWrite(linkWrite),
    .jumpCode(jumpCode), .funcCode(funcCode), .condFlags(condFlags),
    .nextAddr(nextAddr), .incAddr(incAddr), .rowAddr(rowAddr), .bankSelN(bankSelN)
  );

  function automatic int incOf(int a);
    return (a / 64) * 64 + ((a % 64) + 1) % 64;
  endfunction

  function automatic int branchOf();
    int b = 0;
    int j = jumpCode;
    int f = funcCode;
    if (j >= 16 && j < 128 && (j % 8) != 7) b = condFlags[j % 8];
    if ((f / 8) == 6 && condFlags[f % 8]) b = 1;
    return b;
  endfunction

  function automatic int expAddr();
    int c = curAddr;
    int hi = (c / 16384) * 16384;
    int a;
    if (repeatCur) return c;
    if (taskSwitch) return hi + (savedPc % 16384);
    if (isReturn) a = linkWrite ? int'(linkBus) : incOf(c);
    else a = hi + (targetAddr % 16384);
    if (branchOf() != 0 && (a % 2) == 0) a = a + 1;
    return a;
  endfunction

  function automatic logic [3:0] expBank(int a);
    int code = ((a / 2048) % 2) * 2 + (a % 2);
    case (code)
      0: return 4'b0111;
      1: return 4'b1011;
      2: return 4'b1101;
      default: return 4'b1110;
    endcase
  endfunction

  function automatic string pathTag();
    if (repeatCur) return "R1";
    if (taskSwitch) return "R2";
    if (isReturn) return "R5";
    return "R3";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs already set; clock one edge and compare all outputs
  task automatic step(string tag);
    int eA = expAddr();
    int eI = incOf(curAddr);
    string p = pathTag();
    @(posedge clk);
    #1;
    check({tag, " ", p, " nextAddr"}, nextAddr, eA);
    check({tag, " R4 incAddr"}, incAddr, eI);
    check({tag, " R10 rowAddr"}, rowAddr, eA / 2);
    check({tag, " R11 bankSelN"}, bankSelN, expBank(eA));
  endtask

  task automatic setup(logic [15:0] c, logic r, logic s, logic ret, logic lw,
                       logic [7:0] j, logic [7:0] f, logic [7:0] fl);
    curAddr = c; repeatCur = r; taskSwitch = s; isReturn = ret; linkWrite = lw;
    jumpCode = j; funcCode = f; condFlags = fl;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    savedPc = 16'h9abc; targetAddr = 16'h5a5a; linkBus = 16'h4321;
    curAddr = 16'hffff; repeatCur = 1;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset values
    check("R12 nextAddr", nextAddr, 0);
    check("R12 incAddr", incAddr, 0);
    check("R12 rowAddr", rowAddr, 0);
    check("R12 bankSelN", bankSelN, 4'b0111);
    rstN = 1;

    // R1 hold beats switch and a true branch
    setup(16'hc812, 1, 1, 0, 0, 8'o20, 8'o60, 8'hff); step("R1 hold");
    // R2 switch keeps top bits, branch ignored
    setup(16'h4000, 0, 1, 1, 0, 8'o20, 8'o60, 8'hff); step("R2 switch");
    // R3 target, no condition
    targetAddr = 16'h3ffe;
    setup(16'h8000, 0, 0, 0, 0, 8'o20, 8'o0, 8'h00); step("R3 target");
    // R6/R7 each selector in window with only that flag set
    for (int s = 0; s < 7; s++) begin
      setup(16'h0000, 0, 0, 0, 0, 8'(8'o20 + s), 8'o0, 8'(1 << s));
      step("R6 selector");
    end
    // R7 selector 7 excluded, code boundaries excluded
    setup(16'h0000, 0, 0, 0, 0, 8'o27, 8'o0, 8'hff); step("R7 sel7");
    setup(16'h0000, 0, 0, 0, 0, 8'o17, 8'o0, 8'hff); step("R7 low edge");
    setup(16'h0000, 0, 0, 0, 0, 8'o200, 8'o0, 8'hff); step("R7 high edge");
    setup(16'h0000, 0, 0, 0, 0, 8'o177 - 8'o1, 8'o0, 8'hff); step("R7 top in");
    // R8 function-code condition, outside jump window
    setup(16'h0000, 0, 0, 0, 0, 8'o300, 8'o65, 8'h20); step("R8 func");
    setup(16'h0000, 0, 0, 0, 0, 8'o300, 8'o75, 8'h20); step("R8 func off");
    // R9 OR not add: target odd plus both conditions true
    targetAddr = 16'h0801;
    setup(16'h0000, 0, 0, 0, 0, 8'o21, 8'o61, 8'h02); step("R9 or");
    // R5 return with increment wrapping the page, and link
    setup(16'h123f, 0, 0, 1, 0, 8'o300, 8'o0, 8'h00); step("R5 inc wrap");
    setup(16'h123e, 0, 0, 1, 0, 8'o22, 8'o0, 8'h04); step("R5 inc odd R9");
    setup(16'h1234, 0, 0, 1, 1, 8'o20, 8'o0, 8'h01); step("R5 link");
    // R11 all bank codes
    for (int k = 0; k < 4; k++) begin
      targetAddr = 16'((k / 2) * 16'h0800 + (k % 2));
      setup(16'h0000, 0, 0, 0, 0, 8'o300, 8'o0, 8'h00); step("R11 bank");
    end
    // Random sweep
    for (int i = 0; i < 300; i++) begin
      savedPc = 16'($urandom); targetAddr = 16'($urandom); linkBus = 16'($urandom);
      setup(16'($urandom), ($urandom % 5) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0,
            $urandom % 2 == 1, 8'($urandom), 8'(($urandom % 2) ? 8'o60 + $urandom % 8 : $urandom),
            8'($urandom));
      step("random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule